// File: doc/BRIEF.md
# Dual-Bank Programmable Baud Generator

This block holds eight independent clock dividers that all run from one reference clock. Each divider produces a one-cycle tick strobe and a square-wave serial clock. Serial controllers elsewhere use these outputs as their bit-rate timing. Each divider has a 32-bit configuration word, which is written and read over a small register bus. The eight words sit in two separate groups of four. A group select and an index within the group pick one word, so channel number = group * 4 + index.

Each configuration word has three fields: a run enable, a select for a fixed divide-by-16 prescaler, and a 12-bit divisor N. While the channel runs, the prescaler produces advance pulses, and the divider counts N+1 advance pulses per output period. Two common settings follow from this. For 16x oversampled asynchronous links, software sets N+1 to (reference / 16) / baud. For fast synchronous links, it sets N+1 to reference / rate. A new divisor does not cut the running period short; it is taken up at the next terminal count.

Top module: `bgen_bank`

## Requirements
- R1: After reset, every configuration word reads zero, and every tick and serial clock output is low.
- R2: A write with group g and index i updates only channel g*4+i, and a read with the same select returns that channel's word. The other channels' outputs stay low while they are disabled.
- R3: The word layout is: bit 0 prescale select, bits 12:1 divisor N, bit 16 enable. All other bits are dropped on write and read as zero.
- R4: From the second cycle after a write clears the enable, the channel's tick and serial clock stay low.
- R5: With the prescaler off, ticks come every N+1 cycles. The first tick is seen in cycle N+2 after the enabling write edge. For N of 1 or more, no two ticks fall in adjacent cycles.
- R6: With the prescaler on, ticks come every 16*(N+1) cycles, and no two ticks fall in adjacent cycles.
- R7: The serial clock changes state on the advance pulse where the count reaches floor(N/2), and again at the terminal count. For N of 1 or more it is high for N-floor(N/2) advance intervals in each period. For N=0 it toggles on every advance.
- R8: A new divisor is loaded only at a terminal count. The period in progress keeps the old length. If the write lands on the same edge as a terminal count, the old divisor runs for one more full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_grp_i | input | 1 | Register group select |
| bus_idx_i | input | 2 | Channel index within the group |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the selected word (combinational) |
| tick_o | output | 8 | One-cycle strobe per channel at terminal count |
| sclk_o | output | 8 | Square-wave serial clock per channel |

## Verification
Two functions can fall on the same clock edge: a divisor rewrite from the bus, and the divider's terminal count, which reloads the divisor. The bench times a write so that it lands exactly on the edge that ends a period. It then measures the next three tick intervals and expects old, old, new. A write placed in the middle of a period must give old, then new.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
  localparam int WORD_W  = 32;
  localparam int DIV_W   = 12;
  localparam int PRE_BIT = 0;
  localparam int DIV_LSB = 1;
  localparam int EN_BIT  = 16;

  typedef struct packed {
    logic             en;
    logic [DIV_W-1:0] div;
    logic             pre;
  } cfg_t;

  function automatic cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.en  = w[EN_BIT];
    c.div = w[DIV_LSB +: DIV_W];
    c.pre = w[PRE_BIT];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[EN_BIT]            = c.en;
    w[DIV_LSB +: DIV_W]  = c.div;
    w[PRE_BIT]           = c.pre;
    return w;
  endfunction
endpackage

// File: rtl/bgen_regs.sv
module bgen_regs
  import bgen_pkg::*;
#(
  parameter int GRP_CH  = 4,
  parameter int NUM_GRP = 2,
  localparam int NUM_CH = GRP_CH * NUM_GRP,
  localparam int IDX_W  = (GRP_CH > 1) ? $clog2(GRP_CH) : 1,
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output cfg_t              cfg_o [NUM_CH]
);
  logic [NUM_CH-1:0] hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    assign hit[c] = (grp_i == GRP_W'(c / GRP_CH)) && (idx_i == IDX_W'(c % GRP_CH));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cfg_o[c] <= '0;
      else if (we_i && hit[c]) cfg_o[c] <= word_to_cfg(wdata_i);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (hit[c]) rdata_o = cfg_to_word(cfg_o[c]);
  end
endmodule

// File: rtl/bgen_prescale.sv
module bgen_prescale #(
  parameter int PRE_DIV = 16,
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pre_sel_i,
  output logic adv_o
);
  logic [PW-1:0] cnt_q;
  logic          wrap;

  assign wrap  = (cnt_q == PW'(PRE_DIV - 1));
  // free-running while active so a prescale toggle never stalls the divider
  assign adv_o = run_i && (!pre_sel_i || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bgen_divider.sv
module bgen_divider #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             adv_i,
  output logic             run_o,
  output logic             tick_o,
  output logic             sclk_o
);
  logic [DIV_W-1:0] cnt_q, cur_q;
  logic             term;

  assign term = (cnt_q == cur_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0; tick_o <= 1'b0; sclk_o <= 1'b0;
      cnt_q <= '0;   cur_q  <= '0;
    end else if (!en_i) begin
      run_o <= 1'b0; tick_o <= 1'b0; sclk_o <= 1'b0;
      cnt_q <= '0;
    end else if (!run_o) begin
      run_o  <= 1'b1;
      tick_o <= 1'b0;
      cnt_q  <= '0;
      cur_q  <= div_i;
    end else begin
      tick_o <= adv_i && term;
      if (adv_i) begin
        if (term) begin
          cnt_q  <= '0;
          cur_q  <= div_i;           // reload only at period end
          sclk_o <= ~sclk_o;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == (cur_q >> 1)) sclk_o <= ~sclk_o;
        end
      end
    end
  end
endmodule

// File: rtl/bgen_bank.sv
module bgen_bank
  import bgen_pkg::*;
#(
  parameter int GRP_CH  = 4,
  parameter int NUM_GRP = 2,
  parameter int PRE_DIV = 16,
  localparam int NUM_CH = GRP_CH * NUM_GRP,
  localparam int IDX_W  = (GRP_CH > 1) ? $clog2(GRP_CH) : 1,
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [GRP_W-1:0]  bus_grp_i,
  input  logic [IDX_W-1:0]  bus_idx_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0] tick_o,
  output logic [NUM_CH-1:0] sclk_o
);
  cfg_t cfg_q [NUM_CH];

  bgen_regs #(.GRP_CH(GRP_CH), .NUM_GRP(NUM_GRP)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .grp_i   (bus_grp_i),
    .idx_i   (bus_idx_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .cfg_o   (cfg_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic run, adv;

    bgen_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .pre_sel_i (cfg_q[c].pre),
      .adv_o     (adv)
    );

    bgen_divider #(.DIV_W(DIV_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (cfg_q[c].en),
      .div_i  (cfg_q[c].div),
      .adv_i  (adv),
      .run_o  (run),
      .tick_o (tick_o[c]),
      .sclk_o (sclk_o[c])
    );
  end
endmodule

// File: rtl/bgen_bank_chk.sv
module bgen_bank_chk
  import bgen_pkg::*;
#(
  parameter int GRP_CH  = 4,
  parameter int NUM_GRP = 2,
  localparam int NUM_CH = GRP_CH * NUM_GRP,
  localparam int IDX_W  = (GRP_CH > 1) ? $clog2(GRP_CH) : 1,
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [GRP_W-1:0]  grp_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic [WORD_W-1:0] rdata_i,
  input cfg_t              cfg_i [NUM_CH],
  input logic [NUM_CH-1:0] tick_i,
  input logic [NUM_CH-1:0] sclk_i
);
  localparam logic [WORD_W-1:0] LIVE = cfg_to_word('1);

  assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i & ~LIVE) == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_write_decode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && grp_i == GRP_W'(c / GRP_CH) && idx_i == IDX_W'(c % GRP_CH))
      |=> (cfg_i[c] == word_to_cfg($past(wdata_i))));

    assert_idle_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_i[c].en |=> (!tick_i[c] && !sclk_i[c]));

    assert_tick_needs_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i[c] |-> $past(cfg_i[c].en));

    assert_pre_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i[c] && cfg_i[c].pre && $past(cfg_i[c].pre)) |=> (!tick_i[c] || !cfg_i[c].pre));
  end
endmodule

bind bgen_bank bgen_bank_chk #(.GRP_CH(GRP_CH), .NUM_GRP(NUM_GRP)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (bus_we_i),
  .grp_i   (bus_grp_i),
  .idx_i   (bus_idx_i),
  .wdata_i (bus_wdata_i),
  .rdata_i (bus_rdata_o),
  .cfg_i   (cfg_q),
  .tick_i  (tick_o),
  .sclk_i  (sclk_o)
);

// File: tb/bgen_bank_bench.sv
module bgen_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [0:0]  grp = '0;
  logic [1:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  tick, sclk;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bgen_bank u_bgen_bank (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_grp_i(grp), .bus_idx_i(idx),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_o(tick), .sclk_o(sclk)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input bit en, input bit pre, input int n);
    return (32'(en) << 16) | (32'(n & 12'hFFF) << 1) | 32'(pre);
  endfunction

  task automatic wr(input int ch, input logic [31:0] d);
    we = 1'b1; grp = 1'(ch / 4); idx = 2'(ch % 4); wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int ch, output logic [31:0] d);
    grp = 1'(ch / 4); idx = 2'(ch % 4);
    #1 d = rdata;
  endtask

  task automatic wait_tick(input int ch, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick[ch] && n < 5000);
  endtask

  task automatic run_case(input int ch, input bit pre, input int n);
    int p, w, cnt, tk, hi, other, consec, exp_hi;
    bit prev;
    p = pre ? 16 : 1;
    wr(ch, word(1, pre, n));
    if (!pre) begin
      cnt = 0;
      while (!tick[ch] && cnt < 200) begin @(negedge clk); cnt++; end
      check(cnt == n + 2, "R5", $sformatf("first tick latency ch%0d n%0d", ch, n), cnt, n + 2);
    end else begin
      wait_tick(ch, cnt);
    end
    w = 2 * (n + 1) * p;
    tk = 0; hi = 0; other = 0; consec = 0; prev = 1;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      tk += int'(tick[ch]);
      hi += int'(sclk[ch]);
      if (tick[ch] && prev) consec++;
      prev = tick[ch];
      for (int k = 0; k < 8; k++)
        if (k != ch && (tick[k] || sclk[k])) other++;
    end
    check(tk == 2, pre ? "R6" : "R5", $sformatf("ticks in two periods ch%0d n%0d", ch, n), tk, 2);
    exp_hi = (n == 0) ? p : 2 * (n - n / 2) * p;
    check(hi == exp_hi, "R7", $sformatf("sclk high cycles ch%0d n%0d pre%0d", ch, n, pre), hi, exp_hi);
    check(other == 0, "R2", $sformatf("idle neighbours of ch%0d", ch), other, 0);
    if (n >= 1 || pre)
      check(consec == 0, pre ? "R6" : "R5", $sformatf("adjacent ticks ch%0d n%0d", ch, n), consec, 0);
    wr(ch, 32'h0);
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick != 0 || sclk != 0) cnt++;
    end
    check(cnt == 0, "R4", $sformatf("disabled ch%0d stays low", ch), cnt, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, wv;
    int n1, n2, n3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int c = 0; c < 8; c++) begin
      rd(c, d);
      check(d == 32'h0, "R1", $sformatf("reset word ch%0d", c), d, 0);
    end
    check(tick == 0 && sclk == 0, "R1", "reset outputs", {tick, sclk}, 0);

    // R2/R3: decode and field masking, reserved bits set on write
    for (int c = 0; c < 8; c++) begin
      wv = 32'hFFFE_E000 | (32'(c * 37 + 1) << 1) | 32'(c & 1);
      wr(c, wv);
    end
    for (int c = 0; c < 8; c++) begin
      wv = 32'hFFFE_E000 | (32'(c * 37 + 1) << 1) | 32'(c & 1);
      rd(c, d);
      check(d == (wv & 32'h0001_1FFF), "R3", $sformatf("readback ch%0d", c), d, wv & 32'h0001_1FFF);
    end
    for (int c = 0; c < 8; c++) wr(c, 32'h0);
    wr(5, 32'hFFFF_FFFF);
    rd(5, d);
    check(d == 32'h0001_1FFF, "R3", "all-ones write ch5", d, 32'h0001_1FFF);
    rd(1, d);
    check(d == 32'h0, "R2", "group 0 index 1 untouched by group 1 write", d, 0);
    wr(5, 32'h0);
    repeat (2) @(negedge clk);

    // R5/R7: sweep divisor without prescaler across all channels
    for (int n = 0; n < 24; n++) run_case(n % 8, 1'b0, n);
    // R6/R7: prescaler on
    for (int n = 0; n < 6; n++) run_case((n + 3) % 8, 1'b1, n);

    // R8: mid-period divisor change, 5 -> 2
    wr(2, word(1, 0, 5));
    wait_tick(2, n1);
    repeat (2) @(negedge clk);
    wr(2, word(1, 0, 2));
    wait_tick(2, n2);
    check(3 + n2 == 6, "R8", "period holding the write keeps old length", 3 + n2, 6);
    wait_tick(2, n3);
    check(n3 == 3, "R8", "new divisor after terminal count", n3, 3);
    wr(2, 32'h0);

    // R8: write lands on the terminal-count edge, 4 -> 1
    wr(3, word(1, 0, 4));
    wait_tick(3, n1);
    repeat (4) @(negedge clk);
    wr(3, word(1, 0, 1));
    check(tick[3] == 1'b1, "R8", "tick on colliding edge", tick[3], 1);
    wait_tick(3, n2);
    check(n2 == 5, "R8", "old divisor reused after collision", n2, 5);
    wait_tick(3, n3);
    check(n3 == 2, "R8", "new divisor one period later", n3, 2);
    wr(3, 32'h0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule